// File: doc/BRIEF.md
# Stepped Regulator Code Serial Loader

This block programs a core-voltage regulator over a three-wire serial port made of a data line, a shift clock and an active-high load strobe. A requested clock frequency in kHz is turned into a 12-bit regulator code. The block then walks its current code toward that code in steps of bounded size. Each step is written as one complete serial word followed by one load pulse. Because the steps are bounded, the supply never moves far enough in one go to make the regulator drop out.

A controller pulses `start_i` with the frequency on `freq_khz_i`. `force_i` tells the block that the supply is already near the target, so the first word may jump straight there. `busy_o` stays high until the final load pulse is over. `code_o` always shows the last code that was latched into the regulator. Every serial phase lasts `PHASE_CYC` system clocks, which sets the pace of the serial port.

Top module: `vreg_step_loader`

## Requirements
- R1: The target code is 0xFFF when the frequency is below 200000 kHz. It is 0xDE5 for 200000 up to and including 299999 kHz. It is 0x325 for 300000 kHz and above. The frequency is sampled with `start_i`.
- R2: Each word has 12 bits and is sent most significant bit first. There is one rising edge of `sclk_o` per bit, and the receiver samples on that edge. `sdata_o` changes only while `sclk_o` is low.
- R3: After the 12th clock pulse, `sload_o` pulses high once to latch the word. `sclk_o` and `sload_o` are never high together, and both are low whenever the block is idle.
- R4: Without force, the next word is chosen from the current code as follows. If the current code is more than 0x100 below the target, the word is current + 0x100. If it is more than 0x100 above the target, the word is current − 0x100. Otherwise the word is the target. No two consecutive words differ by more than 0x100.
- R5: Words are sent until the last latched word equals the target. Every accepted request sends at least one word, even when the current code already equals the target.
- R6: When `force_i` is high at the start, the first word is the target itself. All later steps follow the rule in R4.
- R7: Each serial phase lasts `PHASE_CYC` clocks, and each word takes 37 phases: three per bit plus one for the load pulse. `busy_o` is therefore high for exactly 37·`PHASE_CYC` clocks per word sent.
- R8: `busy_o` rises on the clock edge that accepts a start and falls when the final load pulse ends. A start pulse that arrives while busy changes neither the words sent nor the final code.
- R9: `code_o` resets to 0. It changes only as a load pulse ends, and it then equals the word just latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_khz_i | input | FREQ_W | Requested core frequency in kHz |
| start_i | input | 1 | Request strobe, taken only when idle |
| force_i | input | 1 | First word goes straight to the target |
| sdata_o | output | 1 | Serial data to the regulator |
| sclk_o | output | 1 | Serial shift clock |
| sload_o | output | 1 | Active-high latch strobe |
| busy_o | output | 1 | Sequence in progress |
| code_o | output | CODE_W | Code most recently latched |

## Verification
`busy_o` rises on the edge that samples `start_i`. It stays high for exactly 37·`PHASE_CYC` clocks per word, so the bench counts busy cycles at falling edges and compares the count with the number of words times 148 (with `PHASE_CYC` = 4). Words are reassembled by a monitor that is driven by the serial edges themselves. The monitor samples data on each `sclk_o` rise and captures the word on each `sload_o` rise, so its result does not depend on the exact cycle. Final codes and busy state are sampled only after `busy_o` has fallen, which is the same edge on which `code_o` takes its last value.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SET   = 3'd1,
        PH_RISE  = 3'd2,
        PH_FALL  = 3'd3,
        PH_LATCH = 3'd4
    } phase_e;

endpackage

// File: rtl/vstep_target.sv
module vstep_target #(
    parameter int FREQ_W    = 20,
    parameter int CODE_W    = 12,
    parameter int MID_KHZ   = 200000,
    parameter int FAST_KHZ  = 300000,
    parameter int CODE_SLOW = 'hFFF,
    parameter int CODE_MID  = 'hDE5,
    parameter int CODE_FAST = 'h325
) (
    input  logic [FREQ_W-1:0] freq_khz,
    output logic [CODE_W-1:0] target
);
    localparam logic [FREQ_W-1:0] MID_F  = FREQ_W'(MID_KHZ);
    localparam logic [FREQ_W-1:0] FAST_F = FREQ_W'(FAST_KHZ);

    always_comb begin
        if (freq_khz < MID_F) begin
            target = CODE_W'(CODE_SLOW);
        end else if (freq_khz < FAST_F) begin
            target = CODE_W'(CODE_MID);
        end else begin
            target = CODE_W'(CODE_FAST);
        end
    end
endmodule

// File: rtl/vstep_next.sv
module vstep_next #(
    parameter int CODE_W = 12,
    parameter int STEP   = 'h100
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] tgt,
    input  logic              jump,
    output logic [CODE_W-1:0] nxt
);
    localparam logic [CODE_W:0] STEP_W = (CODE_W+1)'(STEP);

    logic [CODE_W:0] cur_w;
    logic [CODE_W:0] tgt_w;
    logic [CODE_W:0] up_w;
    logic [CODE_W:0] lim_w;

    always_comb begin
        cur_w = {1'b0, cur};
        tgt_w = {1'b0, tgt};
        up_w  = cur_w + STEP_W;
        lim_w = tgt_w + STEP_W;
        if (jump) begin
            nxt = tgt;
        end else if (up_w < tgt_w) begin
            nxt = up_w[CODE_W-1:0];
        end else if (cur_w > lim_w) begin
            nxt = cur - STEP_W[CODE_W-1:0];
        end else begin
            nxt = tgt;
        end
    end
endmodule

// File: rtl/vstep_phase_timer.sv
module vstep_phase_timer #(
    parameter int PHASE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/vreg_step_loader.sv
module vreg_step_loader #(
    parameter int FREQ_W    = 20,
    parameter int CODE_W    = 12,
    parameter int STEP      = 'h100,
    parameter int PHASE_CYC = 100,
    parameter int MID_KHZ   = 200000,
    parameter int FAST_KHZ  = 300000,
    parameter int CODE_SLOW = 'hFFF,
    parameter int CODE_MID  = 'hDE5,
    parameter int CODE_FAST = 'h325
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_khz_i,
    input  logic              start_i,
    input  logic              force_i,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              sload_o,
    output logic              busy_o,
    output logic [CODE_W-1:0] code_o
);
    import vstep_pkg::*;

    localparam int BIT_W = $clog2(CODE_W);
    localparam logic [BIT_W-1:0] MSB = BIT_W'(CODE_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [BIT_W-1:0]  bit_idx;
        logic [CODE_W-1:0] word;
        logic [CODE_W-1:0] tgt;
        logic [CODE_W-1:0] cur;
        logic              sdata;
        logic              sclk;
        logic              sload;
        logic              busy;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              tick;
    logic [CODE_W-1:0] req_tgt;
    logic [CODE_W-1:0] step_cur;
    logic [CODE_W-1:0] step_tgt;
    logic              step_jump;
    logic [CODE_W-1:0] step_word;
    logic [BIT_W-1:0]  idx_m1;

    vstep_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.ph != PH_IDLE),
        .tick  (tick)
    );

    vstep_target #(
        .FREQ_W    (FREQ_W),
        .CODE_W    (CODE_W),
        .MID_KHZ   (MID_KHZ),
        .FAST_KHZ  (FAST_KHZ),
        .CODE_SLOW (CODE_SLOW),
        .CODE_MID  (CODE_MID),
        .CODE_FAST (CODE_FAST)
    ) u_target (
        .freq_khz (freq_khz_i),
        .target   (req_tgt)
    );

    // In idle the step starts from the latched code; between loads it starts
    // from the word that is being latched in the current phase.
    assign step_cur  = (s_q.ph == PH_IDLE) ? s_q.cur : s_q.word;
    assign step_tgt  = (s_q.ph == PH_IDLE) ? req_tgt : s_q.tgt;
    assign step_jump = (s_q.ph == PH_IDLE) && force_i;

    vstep_next #(
        .CODE_W (CODE_W),
        .STEP   (STEP)
    ) u_next (
        .cur  (step_cur),
        .tgt  (step_tgt),
        .jump (step_jump),
        .nxt  (step_word)
    );

    assign idx_m1 = s_q.bit_idx - 1'b1;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.tgt     = req_tgt;
                    s_d.word    = step_word;
                    s_d.bit_idx = MSB;
                    s_d.sdata   = step_word[MSB];
                    s_d.busy    = 1'b1;
                    s_d.ph      = PH_SET;
                end
            end
            PH_SET: begin
                if (tick) begin
                    s_d.sclk = 1'b1;
                    s_d.ph   = PH_RISE;
                end
            end
            PH_RISE: begin
                if (tick) begin
                    s_d.sclk = 1'b0;
                    s_d.ph   = PH_FALL;
                end
            end
            PH_FALL: begin
                if (tick) begin
                    if (s_q.bit_idx == '0) begin
                        s_d.sload = 1'b1;
                        s_d.ph    = PH_LATCH;
                    end else begin
                        s_d.bit_idx = idx_m1;
                        s_d.sdata   = s_q.word[idx_m1];
                        s_d.ph      = PH_SET;
                    end
                end
            end
            PH_LATCH: begin
                if (tick) begin
                    s_d.sload = 1'b0;
                    s_d.cur   = s_q.word;
                    if (s_q.word == s_q.tgt) begin
                        s_d.busy  = 1'b0;
                        s_d.sdata = 1'b0;
                        s_d.ph    = PH_IDLE;
                    end else begin
                        s_d.word    = step_word;
                        s_d.bit_idx = MSB;
                        s_d.sdata   = step_word[MSB];
                        s_d.ph      = PH_SET;
                    end
                end
            end
            default: begin
                s_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdata_o = s_q.sdata;
    assign sclk_o  = s_q.sclk;
    assign sload_o = s_q.sload;
    assign busy_o  = s_q.busy;
    assign code_o  = s_q.cur;
endmodule

// File: rtl/vstep_checker.sv
module vstep_checker #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdata_o,
    input logic              sclk_o,
    input logic              sload_o,
    input logic              busy_o,
    input logic [CODE_W-1:0] code_o
);
    a_r3_clk_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_o && sload_o));

    a_r3_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !sload_o));

    a_r2_data_steady_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdata_o));

    a_r9_code_moves_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> $fell(sload_o));

    a_r8_busy_ends_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $fell(sload_o));
endmodule

bind vreg_step_loader vstep_checker #(.CODE_W(CODE_W)) u_vstep_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdata_o (sdata_o),
    .sclk_o  (sclk_o),
    .sload_o (sload_o),
    .busy_o  (busy_o),
    .code_o  (code_o)
);

// File: tb/tb_vreg_step_loader.sv
module tb_vreg_step_loader;
    localparam int P        = 4;
    localparam int PER_WORD = 37 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] freq = '0;
    logic        start = 1'b0;
    logic        frc = 1'b0;
    logic        sdata, sclk, sload, busy;
    logic [11:0] code;

    always #5 clk = ~clk;

    vreg_step_loader #(.PHASE_CYC(P)) dut (
        .clk(clk), .rst_n(rst_n), .freq_khz_i(freq), .start_i(start),
        .force_i(frc), .sdata_o(sdata), .sclk_o(sclk), .sload_o(sload),
        .busy_o(busy), .code_o(code)
    );

    // Monitor: rebuilds words from the serial lines.
    logic        mon_clr = 1'b0;
    logic [11:0] shreg = '0;
    logic [11:0] first_w = '0;
    logic [11:0] prev_w = '0;
    int          nwords = 0;
    int          nviol = 0;

    always @(posedge sclk or posedge sload or posedge mon_clr) begin
        if (mon_clr) begin
            nwords = 0;
            nviol  = 0;
        end else if (sload) begin
            if (nwords == 0) begin
                first_w = shreg;
            end else if ((shreg > prev_w ? shreg - prev_w : prev_w - shreg) > 12'h100) begin
                nviol = nviol + 1;
            end
            prev_w = shreg;
            nwords = nwords + 1;
        end else begin
            shreg = {shreg[10:0], sdata};
        end
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {freq[19:0], force, first word[11:0], final code[11:0], word count[7:0]}
    localparam logic [52:0] VECS [8] = '{
        {20'd350000, 1'b1, 12'h325, 12'h325, 8'd1},
        {20'd250000, 1'b0, 12'h425, 12'hDE5, 8'd11},
        {20'd100000, 1'b0, 12'hEE5, 12'hFFF, 8'd3},
        {20'd299999, 1'b0, 12'hEFF, 12'hDE5, 8'd3},
        {20'd300000, 1'b1, 12'h325, 12'h325, 8'd1},
        {20'd300000, 1'b0, 12'h325, 12'h325, 8'd1},
        {20'd199999, 1'b0, 12'h425, 12'hFFF, 8'd13},
        {20'd200000, 1'b0, 12'hEFF, 12'hDE5, 8'd3}
    };

    task automatic run_req(input logic [19:0] f, input logic fo, input bit inject,
                           output int bcyc);
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        freq  = f;
        frc   = fo;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bcyc  = 0;
        while (busy) begin
            bcyc++;
            if (inject && bcyc == 100) begin
                freq  = 20'd350000;
                frc   = 1'b1;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total + 1);
        $finish;
    end

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 reset code", int'(code), 0);
        chk("R3 reset lines", int'({sclk, sload, sdata, busy}), 0);

        for (int i = 0; i < 8; i++) begin
            run_req(VECS[i][52:33], VECS[i][32], 1'b0, bc);
            chk(VECS[i][32] ? "R6 forced first word" : "R4/R2 first word",
                int'(first_w), int'(VECS[i][31:20]));
            chk("R4 step size", nviol, 0);
            chk("R5 word count", nwords, int'(VECS[i][7:0]));
            chk("R1/R9 final code", int'(code), int'(VECS[i][19:8]));
            chk("R7 busy length", bc, int'(VECS[i][7:0]) * PER_WORD);
            chk("R3 idle lines", int'({sclk, sload}), 0);
        end

        // R8: start while busy is ignored (code 0xDE5 -> 0xFFF in three words)
        run_req(20'd100000, 1'b0, 1'b1, bc);
        chk("R8 ignored start first word", int'(first_w), 'hEE5);
        chk("R8 ignored start count", nwords, 3);
        chk("R8 ignored start final", int'(code), 'hFFF);
        chk("R8 busy length", bc, 3 * PER_WORD);
        repeat (3) @(negedge clk);
        chk("R8 stays idle", int'(busy), 0);

        // R9: reset in the middle of a sequence
        @(negedge clk);
        freq  = 20'd350000;
        frc   = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 mid-run reset code", int'(code), 0);
        chk("R9 mid-run reset lines", int'({sclk, sload, sdata, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: stepping upward from zero, last step smaller than 0x100
        run_req(20'd350000, 1'b0, 1'b0, bc);
        chk("R4 first step from zero", int'(first_w), 'h100);
        chk("R5 count from zero", nwords, 4);
        chk("R4 last step to target", int'(prev_w), 'h325);
        chk("R9 code after climb", int'(code), 'h325);
        chk("R7 busy from zero", bc, 4 * PER_WORD);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule